// File: doc/BRIEF.md
# Six-Read Nonvolatile Command Detector

This block sits beside a static RAM port whose accesses arrive as discrete events, each carrying a write flag and an address. It looks for one fixed run of six consecutive reads. The first five addresses are the same for both commands, and the sixth address selects the command. One sixth address asks for the RAM contents to be saved into nonvolatile cells. The other asks for the nonvolatile contents to be copied back into the RAM.

When a command is recognised, the block raises a single-cycle request for the save or the copy-back, meant for a separate operation sequencer. It also disables the RAM port for the time that operation needs. While the port is disabled, every access is ignored. When the time runs out, the detector returns to idle. A supply-low input blocks save requests only.

Top module: `sw_nv_seq_detect`

## Requirements
- R1: Reads of low-14-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, in that order, raise `store_req` for exactly one cycle. The pulse appears in the cycle after the edge that samples the sixth read.
- R2: The same five-read prefix followed by a read of 0x0C63 raises `recall_req` for exactly one cycle, with the same timing as R1.
- R3: Only `acc_addr[13:0]` is compared. Address bit 14 has no effect on matching.
- R4: An access with `acc_write` = 1 at any step discards the progress made so far, and no request follows from it.
- R5: A read whose address is not the next expected one discards the progress made so far. If that read's address is 0x0E38, it counts as the first read of a new run.
- R6: `port_off` rises in the same cycle as a request. It stays high for `STORE_CYCLES` cycles after a save request and for `RECALL_CYCLES` cycles after a copy-back request.
- R7: While `port_off` is high, accesses are ignored and make no progress. The detector is idle when `port_off` falls.
- R8: A save request is raised whenever its sequence is seen, whether or not any write took place since the previous save or copy-back.
- R9: A save sixth read sampled while `supply_low` = 1 raises no request, leaves the port enabled and returns the detector to idle. A copy-back is not blocked by `supply_low`.
- R10: `store_req` and `recall_req` are never high together, and neither stays high for two cycles in a row.
- R11: During reset, all outputs are low and the detector is idle.
- R12: Cycles with `acc_strobe` = 0 neither advance nor discard the progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | One access event is present this cycle |
| acc_write | input | 1 | The access is a write (1) or a read (0) |
| acc_addr | input | ADDR_W | Access address |
| supply_low | input | 1 | Low-supply inhibit; blocks save requests |
| store_req | output | 1 | Single-cycle save request |
| recall_req | output | 1 | Single-cycle copy-back request |
| port_off | output | 1 | RAM port disabled, outputs to be floated |

## Verification
Two functions can fall on the same edge, and both pairings are provoked on purpose.

- **End of operation and a new access.** The bench sends a read on every cycle while the port is disabled, so one read lands on the same edge that ends the busy time. It then sends the remaining five reads of the copy-back command. If that final ignored read had been counted, those five reads would complete a copy-back, so it is judged by the absence of `recall_req`.
- **Discarding and restarting on one access.** A 0x0E38 read is placed in the middle of a run. The bench then sends only the five remaining addresses and expects a save request.

The reference model is compared against the ports on every cycle.

// File: rtl/sw_nv_seq_detect.sv
module sw_nv_seq_detect #(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 2500000,
  parameter int RECALL_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              supply_low,
  output logic              store_req,
  output logic              recall_req,
  output logic              port_off
);
  localparam int KEY_W = 14;
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [KEY_W-1:0] KEY_STORE  = 14'h0FC0;
  localparam logic [KEY_W-1:0] KEY_RECALL = 14'h0C63;

  function automatic logic [KEY_W-1:0] prefix_key(input logic [2:0] idx);
    case (idx)
      3'd0:    return 14'h0E38;
      3'd1:    return 14'h31C7;
      3'd2:    return 14'h03E0;
      3'd3:    return 14'h3C1F;
      default: return 14'h303F;
    endcase
  endfunction

  logic [2:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [KEY_W-1:0] key;

  assign key = acc_addr[KEY_W-1:0];

  wire in_prefix = step < 3'd5;
  wire hit_pre   = in_prefix && (key == prefix_key(step));
  wire hit_store = !in_prefix && (key == KEY_STORE) && !supply_low;
  wire hit_rec   = !in_prefix && (key == KEY_RECALL);
  wire restart   = key == prefix_key(3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= '0;
      cnt        <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      port_off   <= 1'b0;
    end else begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      if (port_off) begin
        if (cnt == '0) port_off <= 1'b0;
        else           cnt      <= cnt - 1'b1;
      end else if (acc_strobe) begin
        if (acc_write) begin
          step <= '0;
        end else if (hit_pre) begin
          step <= step + 1'b1;
        end else if (hit_store) begin
          step      <= '0;
          store_req <= 1'b1;
          port_off  <= 1'b1;
          cnt       <= CNT_W'(STORE_CYCLES - 1);
        end else if (hit_rec) begin
          step       <= '0;
          recall_req <= 1'b1;
          port_off   <= 1'b1;
          cnt        <= CNT_W'(RECALL_CYCLES - 1);
        end else begin
          step <= restart ? 3'd1 : 3'd0;
        end
      end
    end
  end

  assert_req_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  assert_store_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  assert_recall_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  assert_off_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_off) |-> (store_req || recall_req));
  assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_off |-> cnt == '0);
  assert_busy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_off |-> step == 3'd0);
  assert_store_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> !$past(supply_low));
endmodule

// File: tb/sw_nv_seq_detect_bench.sv
module sw_nv_seq_detect_bench;
  localparam int SC = 40;
  localparam int RC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_strobe = 1'b0, acc_write = 1'b0, supply_low = 1'b0;
  logic [14:0] acc_addr = '0;
  logic store_req, recall_req, port_off;

  always #2 clk = ~clk;

  sw_nv_seq_detect #(.ADDR_W(15), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u_sw_nv_seq_detect (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_write(acc_write),
    .acc_addr(acc_addr), .supply_low(supply_low),
    .store_req(store_req), .recall_req(recall_req), .port_off(port_off));

  int tests = 0, fails = 0;
  int ns = 0, nr = 0;
  int mstep = 0, mbusy = 0;
  logic es = 1'b0, er = 1'b0;
  logic p_s = 1'b0, p_w = 1'b0, p_l = 1'b0;
  logic [14:0] p_a = '0;
  logic lowv = 1'b0;
  int pre[5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model();
    int k;
    k = int'(p_a[13:0]);
    es = 1'b0; er = 1'b0;
    if (mbusy > 0) mbusy--;
    else if (p_s) begin
      if (p_w) mstep = 0;
      else if (mstep < 5 && k == pre[mstep]) mstep++;
      else if (mstep == 5 && k == 'h0FC0 && !p_l) begin es = 1; mbusy = SC; mstep = 0; end
      else if (mstep == 5 && k == 'h0C63) begin er = 1; mbusy = RC; mstep = 0; end
      else mstep = (k == 'h0E38) ? 1 : 0;
    end
  endtask

  task automatic tick(input logic s, input logic w, input logic [14:0] a);
    @(negedge clk);
    model();
    chk("R1 store_req", int'(store_req), int'(es));
    chk("R2 recall_req", int'(recall_req), int'(er));
    chk("R6 port_off", int'(port_off), int'(mbusy > 0));
    ns += int'(store_req);
    nr += int'(recall_req);
    acc_strobe = s; acc_write = w; acc_addr = a; supply_low = lowv;
    p_s = s; p_w = w; p_a = a; p_l = lowv;
  endtask

  task automatic rd(input logic [14:0] a);
    tick(1'b1, 1'b0, a);
    tick(1'b0, 1'b0, 15'h0);
  endtask

  task automatic prefix(input logic hi);
    for (int i = 0; i < 5; i++) rd(15'(pre[i]) | {hi, 14'h0});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 15'h0);
  endtask

  initial begin
    int s0, r0;
    repeat (3) begin
      @(negedge clk);
      chk("R11 reset store_req", int'(store_req), 0);
      chk("R11 reset recall_req", int'(recall_req), 0);
      chk("R11 reset port_off", int'(port_off), 0);
    end
    rst_n = 1'b1;
    idle(2);

    s0 = ns; prefix(0); rd(15'h0FC0); idle(SC + 4);
    chk("R1 one store", ns - s0, 1);

    r0 = nr; prefix(1); rd(15'h4C63); idle(RC + 4);
    chk("R3 bit14 ignored recall", nr - r0, 1);

    s0 = ns; rd(15'h0E38); rd(15'h31C7); tick(1'b1, 1'b1, 15'h03E0); tick(1'b0, 1'b0, 0);
    rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0); idle(4);
    chk("R4 write aborts", ns - s0, 0);

    s0 = ns; rd(15'h0E38); rd(15'h31C7); rd(15'h1234); rd(15'h03E0); rd(15'h3C1F);
    rd(15'h303F); rd(15'h0FC0); idle(4);
    chk("R5 mismatch aborts", ns - s0, 0);

    s0 = ns; rd(15'h0E38); rd(15'h31C7); rd(15'h03E0); rd(15'h0E38);
    rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0); idle(SC + 4);
    chk("R5 restart on first key", ns - s0, 1);

    s0 = ns; prefix(0); tick(1'b1, 1'b0, 15'h0E38); tick(1'b1, 1'b0, 15'h31C7);
    idle(7); tick(1'b1, 1'b0, 15'h03E0); tick(1'b1, 1'b0, 15'h3C1F);
    tick(1'b1, 1'b0, 15'h303F); tick(1'b1, 1'b0, 15'h0FC0); idle(SC + 4);
    chk("R12 idle gaps keep progress", ns - s0, 1);

    s0 = ns; prefix(0); rd(15'h0FC0); idle(SC + 2); prefix(0); rd(15'h0FC0); idle(SC + 2);
    chk("R8 stores without writes", ns - s0, 2);

    lowv = 1'b1;
    s0 = ns; prefix(0); rd(15'h0FC0); idle(3);
    chk("R9 store refused", ns - s0, 0);
    chk("R9 port stays on", int'(port_off), 0);
    r0 = nr; rd(15'h0C63); idle(3);
    chk("R9 idle after refusal", nr - r0, 0);
    prefix(0); rd(15'h0C63); idle(RC + 4);
    chk("R9 recall under low supply", nr - r0, 1);
    lowv = 1'b0;

    prefix(0); tick(1'b1, 1'b0, 15'h0FC0);
    r0 = nr;
    for (int i = 0; i < SC; i++) tick(1'b1, 1'b0, 15'h0E38);
    rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0C63); idle(RC + 4);
    chk("R7 busy accesses ignored", nr - r0, 0);
    prefix(0); rd(15'h0C63); idle(RC + 4);
    chk("R7 idle after operation", nr - r0, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule